// File: doc/BRIEF.md
# Power-of-Two Address Line Tester

This block checks the address wiring between a controller and an external memory for lines that are stuck at a level or shorted to a neighbour. It drives a simple synchronous memory port: a read issued in one cycle returns its data on the next. The test only touches the base address and the base plus each power of two below the memory depth. That is AW+1 locations for an AW-bit address, so the run is short even for a large memory.

A run begins on `start`, and only while `en` is high. The `en` input tells the block that the data lines have already been shown to work, because the result means nothing without that. The block first fills every test location with a fixed pattern and reads each one back. It then takes each location in turn. It writes the complement pattern there, reads every location in the set, and writes the fixed pattern back. At the first wrong read it stops and reports two offsets: the location being read and the location last written. On a clean memory it ends with `done` high and `fail` low.

Top module: `addr_bus_tester`

## Requirements
- R1: After reset `busy`, `done` and `fail` are low, both reported offsets are zero, and no read or write is issued while the block is idle.
- R2: `start` begins a run only when `en` is high and the block is idle. A `start` with `en` low, or a `start` during a run, has no effect.
- R3: Every access uses `base` plus an offset that is zero or a single power of two below 2^AW. The test set is those AW+1 offsets, indexed 0 for offset zero and n for offset 2^(n-1).
- R4: A run first writes the fill pattern to the set in index order (offset 0, 1, 2, 4, ...). The fill pattern is 8'hAA repeated and cut to DW bits; the mark pattern is its complement.
- R5: A verify pass then reads each offset in index order and expects the fill pattern. On a mismatch both reported offsets equal that offset.
- R6: For each target index in order, the block writes the mark pattern to the target, reads the whole set in index order, and then writes the fill pattern back to the target. Each read expects the mark pattern at the target and the fill pattern everywhere else.
- R7: At the first mismatch the block raises `fail` and `done`, drops `busy`, and latches the offset being read in `fail_chk` and the offset last written in `fail_wr`.
- R8: A run on a fault-free memory holds `busy` for exactly 2N²+5N cycles, where N=AW+1, and ends with `done` high and `fail` low.
- R9: If two address bits of the memory are shorted together (wired-AND), the run fails, and `fail_chk` or `fail_wr` has one of those two bits set.
- R10: `done`, `fail` and both offsets keep their values until the next accepted `start`, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Data lines already verified; allows a run |
| start | input | 1 | Begin a run |
| base | input | AW | Base address of the test set |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run finished |
| fail | output | 1 | Last run found a mismatch |
| fail_chk | output | AW | Offset being read at the mismatch |
| fail_wr | output | AW | Offset last written at the mismatch |
| mem_addr | output | AW | Memory address |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe; data returns next cycle |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data |

## Verification
A sequencing fault, such as an index that skips a power of two or misses its restore write, shows up on the memory address lines within one cycle of the bad step. A fault in the compare or in the expected-value choice shows up as a wrong `fail` or a wrong offset pair when the run ends, at most 2N²+5N cycles after `start`. A counter that stops one step early or late changes the length of `busy`, so it is caught as soon as the run ends. Random address shorts, stuck lines and dead cells are scored against an independent model of the algorithm.

// File: rtl/addr_bus_tester.sv
module addr_bus_tester #(
  parameter int AW = 10,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          start,
  input  logic [AW-1:0] base,
  output logic          busy,
  output logic          done,
  output logic          fail,
  output logic [AW-1:0] fail_chk,
  output logic [AW-1:0] fail_wr,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic          mem_re,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);
  localparam int IW = $clog2(AW + 2);
  localparam int NB = (DW + 7) / 8;
  localparam logic [8*NB-1:0] PWIDE = {NB{8'hAA}};
  localparam logic [DW-1:0] PAT = PWIDE[DW-1:0];
  localparam logic [DW-1:0] INV = ~PAT;
  localparam logic [IW-1:0] LAST = IW'(AW);

  typedef enum logic [2:0] {S_IDLE, S_FILL, S_VRD, S_VCMP, S_TWR, S_TRD, S_TCMP, S_TRST} st_t;

  st_t st;
  logic [IW-1:0] k, t;

  function automatic logic [AW-1:0] offs(input logic [IW-1:0] i);
    return (i == '0) ? '0 : ({{(AW-1){1'b0}}, 1'b1} << (i - 1'b1));
  endfunction

  logic [IW-1:0] idx;
  logic [DW-1:0] expd;
  logic          miss;

  assign idx       = (st == S_TWR || st == S_TRST) ? t : k;
  assign mem_addr  = base + offs(idx);
  assign mem_we    = (st == S_FILL) || (st == S_TWR) || (st == S_TRST);
  assign mem_re    = (st == S_VRD) || (st == S_TRD);
  assign mem_wdata = (st == S_TWR) ? INV : PAT;
  assign busy      = (st != S_IDLE);
  assign expd      = (st == S_TCMP && k == t) ? INV : PAT;
  assign miss      = (mem_rdata != expd);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      k        <= '0;
      t        <= '0;
      done     <= 1'b0;
      fail     <= 1'b0;
      fail_chk <= '0;
      fail_wr  <= '0;
    end else begin
      case (st)
        S_IDLE: if (start && en) begin
          st       <= S_FILL;
          k        <= '0;
          t        <= '0;
          done     <= 1'b0;
          fail     <= 1'b0;
          fail_chk <= '0;
          fail_wr  <= '0;
        end
        S_FILL: if (k == LAST) begin
          k  <= '0;
          st <= S_VRD;
        end else k <= k + 1'b1;
        S_VRD: st <= S_VCMP;
        S_VCMP: if (miss) begin
          fail     <= 1'b1;
          done     <= 1'b1;
          fail_chk <= offs(k);
          fail_wr  <= offs(k);
          st       <= S_IDLE;
        end else if (k == LAST) begin
          k  <= '0;
          st <= S_TWR;
        end else begin
          k  <= k + 1'b1;
          st <= S_VRD;
        end
        S_TWR: st <= S_TRD;
        S_TRD: st <= S_TCMP;
        S_TCMP: if (miss) begin
          fail     <= 1'b1;
          done     <= 1'b1;
          fail_chk <= offs(k);
          fail_wr  <= offs(t);
          st       <= S_IDLE;
        end else if (k == LAST) begin
          k  <= '0;
          st <= S_TRST;
        end else begin
          k  <= k + 1'b1;
          st <= S_TRD;
        end
        S_TRST: if (t == LAST) begin
          done <= 1'b1;
          st   <= S_IDLE;
        end else begin
          t  <= t + 1'b1;
          st <= S_TWR;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/abt_chk.sv
module abt_chk #(
  parameter int AW = 10,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          start,
  input logic [AW-1:0] base,
  input logic          busy,
  input logic          done,
  input logic          fail,
  input logic [AW-1:0] fail_chk,
  input logic [AW-1:0] fail_wr,
  input logic [AW-1:0] mem_addr,
  input logic          mem_we,
  input logic          mem_re,
  input logic [DW-1:0] mem_wdata
);
  localparam int NB = (DW + 7) / 8;
  localparam logic [8*NB-1:0] FW = {NB{8'hAA}};
  localparam logic [DW-1:0] FILLP = FW[DW-1:0];

  logic [AW-1:0] rel;
  assign rel = mem_addr - base;

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_we && !mem_re));

  assert_start_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !en) |=> !busy);

  assert_addr_in_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) |-> ($countones(rel) <= 1));

  assert_wdata_pattern_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_wdata == FILLP || mem_wdata == ~FILLP));

  assert_single_access_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_we, mem_re}));

  assert_fail_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail) |-> (done && !busy));

  assert_results_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(start && en)) |=> ($stable(done) && $stable(fail) &&
                                   $stable(fail_chk) && $stable(fail_wr)));
endmodule

bind addr_bus_tester abt_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/addr_bus_tester_tb.sv
module addr_bus_tester_tb;
  localparam int AW = 4;
  localparam int DW = 12;
  localparam int DEPTH = 1 << AW;
  localparam int N = AW + 1;
  localparam logic [DW-1:0] PAT = 12'hAAA;
  localparam logic [DW-1:0] INV = ~PAT;

  logic clk = 0, rst_n = 0, en = 0, start = 0, clr = 0;
  logic [AW-1:0] base = '0;
  logic busy, done, fail, mem_we, mem_re;
  logic [AW-1:0] fail_chk, fail_wr, mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;

  int total = 0, bad = 0;
  int fmode = 0, fi = 0, fj = 0;
  int wcnt = 0, seq_err = 0, set_err = 0;
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] pm [DEPTH];

  always #2 clk = ~clk;

  addr_bus_tester #(.AW(AW), .DW(DW)) u_dut (.*);

  function automatic logic [AW-1:0] off(input int n);
    return (n == 0) ? '0 : AW'(1 << (n - 1));
  endfunction

  // fault modes: 1 short bits fi,fj (AND), 2 bit fi stuck high, 3 bit fi stuck low, 4 dead cell fi
  function automatic logic [AW-1:0] phys(input logic [AW-1:0] a);
    logic [AW-1:0] p = a;
    logic v;
    case (fmode)
      1: begin v = a[fi] & a[fj]; p[fi] = v; p[fj] = v; end
      2: p[fi] = 1'b1;
      3: p[fi] = 1'b0;
      default: ;
    endcase
    return p;
  endfunction

  function automatic bit dead(input logic [AW-1:0] p);
    return fmode == 4 && p == AW'(fi);
  endfunction

  always @(posedge clk) begin
    if (clr) begin
      for (int a = 0; a < DEPTH; a++) mem[a] <= '0;
    end else if (mem_we && !dead(phys(mem_addr))) mem[phys(mem_addr)] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[phys(mem_addr)];
  end

  always @(negedge clk) begin
    if (!busy && start && en) wcnt = 0;
    if (mem_we || mem_re) if ($countones(mem_addr - base) > 1) set_err++;
    if (mem_we && wcnt < N) begin
      if (mem_addr != base + off(wcnt) || mem_wdata != PAT) seq_err++;
      wcnt++;
    end
  end

  function automatic void pwr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    if (!dead(phys(a))) pm[phys(a)] = d;
  endfunction

  function automatic void predict(input logic [AW-1:0] b, output bit pf,
                                  output logic [AW-1:0] pc, output logic [AW-1:0] pw);
    pf = 0; pc = '0; pw = '0;
    for (int a = 0; a < DEPTH; a++) pm[a] = '0;
    for (int n = 0; n < N; n++) pwr(b + off(n), PAT);
    for (int n = 0; n < N; n++)
      if (pm[phys(b + off(n))] != PAT) begin pf = 1; pc = off(n); pw = off(n); return; end
    for (int tt = 0; tt < N; tt++) begin
      pwr(b + off(tt), INV);
      for (int n = 0; n < N; n++)
        if (pm[phys(b + off(n))] != ((n == tt) ? INV : PAT)) begin
          pf = 1; pc = off(n); pw = off(tt); return;
        end
      pwr(b + off(tt), PAT);
    end
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run(input bool_poke, output int cyc);
    @(negedge clk); clr = 1;
    @(negedge clk); clr = 0; en = 1; start = 1;
    @(negedge clk); start = 0;
    cyc = 0;
    while (busy && cyc < 2000) begin
      cyc++;
      if (bool_poke && cyc == 10) start = 1;
      if (bool_poke && cyc == 11) start = 0;
      @(negedge clk);
    end
    if (cyc >= 2000) chk("R8", "watchdog per run", 1, 0);
  endtask

  task automatic scored(input string req);
    bit pf; logic [AW-1:0] pc, pw; int cyc;
    predict(base, pf, pc, pw);
    run(0, cyc);
    chk(req, "done", int'(done), 1);
    chk(req, "fail", int'(fail), int'(pf));
    if (pf) begin
      chk(req, "fail_chk", int'(fail_chk), int'(pc));
      chk(req, "fail_wr", int'(fail_wr), int'(pw));
    end else chk("R8", "busy length", cyc, 2*N*N + 5*N);
  endtask

  initial begin
    #400000;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int cyc;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1", "busy after reset", int'(busy), 0);
    chk("R1", "done after reset", int'(done), 0);
    chk("R1", "fail after reset", int'(fail), 0);
    chk("R1", "no access in reset", int'(mem_we | mem_re), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "fail_chk after reset", int'(fail_chk), 0);
    en = 0; start = 1;
    repeat (3) @(negedge clk);
    chk("R2", "start ignored without en", int'(busy), 0);
    chk("R2", "no access without en", int'(mem_we | mem_re), 0);
    start = 0;

    fmode = 0; base = '0;
    run(1, cyc);
    chk("R2", "start during run ignored (length)", cyc, 2*N*N + 5*N);
    chk("R8", "clean fail", int'(fail), 0);
    repeat (5) @(negedge clk);
    chk("R10", "done held", int'(done), 1);

    fmode = 1; fi = 1; fj = 3; base = '0;
    scored("R9");
    chk("R9", "short bit in offsets", int'(((fail_chk | fail_wr) & AW'((1 << fi) | (1 << fj))) != 0), 1);
    repeat (4) @(negedge clk);
    chk("R10", "fail held", int'(fail), 1);
    fmode = 1; fi = 0; fj = 2; base = '0;
    scored("R9");
    chk("R9", "short bit in offsets", int'(((fail_chk | fail_wr) & AW'((1 << fi) | (1 << fj))) != 0), 1);
    fmode = 2; fi = 2; base = '0;
    scored("R5");
    fmode = 3; fi = 3; base = '0;
    scored("R6");
    fmode = 4; fi = 8; base = '0;
    scored("R5");
    fmode = 0; base = 4'hF;
    scored("R8");

    for (int r = 0; r < 30; r++) begin
      fmode = $urandom_range(0, 4);
      fi = $urandom_range(0, AW - 1);
      fj = $urandom_range(0, AW - 1);
      if (fmode == 4) fi = $urandom_range(0, DEPTH - 1);
      base = AW'($urandom_range(0, DEPTH - 1));
      scored("R7");
    end

    chk("R3", "accesses outside set", set_err, 0);
    chk("R4", "fill order/data errors", seq_err, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule